// File: doc/BRIEF.md
# AC-link Transmit Frame Serializer

This block builds the outgoing frames of an AC'97-style serial audio link and shifts them out one bit per codec bit clock. A frame is 256 bit clocks long: a 16-bit tag slot, then twelve 20-bit slots, each sent most significant bit first. The tag marks which of the following slots carry valid data. Only slots 1 to 4 can carry data, and each has a one-word buffer that a register or DMA side fills.

A slot's buffer is copied into the next frame only when the codec asked for that slot. The request arrives as a flag decoded from the previous received frame. Taking a word sets that slot's empty flag. If the codec asks for a slot whose buffer was not refilled, the block sends the old word again and still marks it valid, so the stream holds its last sample instead of dropping to zero. The frame sync output is high during the tag slot.

Top module: `aclink_tx_framer`

## Requirements
- R1: While reset is held, `sync_out` and `sdata_out` are 0 and all four `buf_empty` bits are 1. The first frame after reset carries an all-zero tag and all-zero slots.
- R2: Frames repeat every 256 bit clocks. `sync_out` is 1 for the 16 bit clocks that carry the tag and 0 for the other 240.
- R3: Each rising edge of `bit_clk` presents one new bit on `sdata_out`. The order is the 16 tag bits, then slots 1 to 12 of 20 bits each, every field most significant bit first.
- R4: Tag bit 15 (the first bit sent) is 1 exactly when any of slots 1 to 4 is valid. Tag bits 14, 13, 12 and 11 mark slots 1, 2, 3 and 4 as valid. Tag bits 10 to 0 are 0.
- R5: `slot_req` is sampled at the rising edge that sends the last bit of slot 12. Bit k of `slot_req` stands for slot k+1. A requested slot is valid in the following frame and carries its buffer word as it stood before that edge. A slot that was not requested sends a 0 tag bit and 20 zero bits.
- R6: Slots 5 to 12 always send zeros.
- R7: A write with `wr_en[k]` high stores `wr_data[19:0]` into the buffer of slot k+1. Bits 31 to 20 of `wr_data` have no effect.
- R8: When a requested slot takes its buffer word, that slot's `buf_empty` bit goes to 1 on the same edge. A write to the slot clears the bit on the edge of the write.
- R9: If a slot is requested again without a new write (underrun), it is marked valid and sends the previously sent word again.
- R10: A write on the same edge as the frame load goes to the buffer, but the frame being loaded carries the older word. That slot's `buf_empty` bit stays 0, and the new word goes out the next time the slot is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Bit clock supplied by the codec |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_req | input | 4 | Slot request flags for slots 1..4, decoded from the previous received frame |
| wr_en | input | 4 | Write strobe, one per data slot buffer |
| wr_data | input | 32 | Write word; the low 20 bits are stored |
| sdata_out | output | 1 | Serial frame data |
| sync_out | output | 1 | Frame sync, high during the tag slot |
| buf_empty | output | 4 | Buffer-empty flag for slots 1..4 |

## Verification
Directed frames cover four cases, and each tells a different fault apart:
- The empty frame after reset separates the reset state from the load path.
- A frame with all four slots freshly written and requested checks the tag positions and the order of the slot fields.
- A repeat request with no write shows the stale word being resent rather than zeros.
- A write on the load edge shows that the frame takes the older word while the flag stays clear.

Random frames then mix request masks, partial writes, coincident writes and junk in the upper write bits. They catch a swapped slot, a mask error, a leak of the upper bits, and a flag that is set or cleared on the wrong edge.

// File: rtl/aclink_tx_pkg.sv
// Package: shared constants for the AC-link transmit framer.
// Assumes a tag slot followed by equal-width data slots, MSB first.
package aclink_tx_pkg;
    localparam int unsigned DEF_TAG_BITS   = 16;
    localparam int unsigned DEF_SLOT_BITS  = 20;
    localparam int unsigned DEF_SLOT_COUNT = 12;
    localparam int unsigned DEF_DATA_SLOTS = 4;
    localparam int unsigned DEF_BUS_BITS   = 32;

    // Larger of two widths; used to size the bit-position counter.
    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/aclink_frame_timer.sv
// Module: frame timer. It tracks the current slot index and the bit position
// inside that slot, counting down from MSB to LSB, and flags the last bit of
// the frame.
// Assumes the slot index 0 is the tag slot and the rest hold SLOT_BITS each.
module aclink_frame_timer #(
    parameter int unsigned TAG_BITS   = 16,
    parameter int unsigned SLOT_BITS  = 20,
    parameter int unsigned SLOT_COUNT = 12,
    parameter int unsigned IDX_W      = 4,
    parameter int unsigned POS_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] slot_idx,
    output logic [POS_W-1:0] bit_pos,
    output logic             frame_last
);
    localparam int unsigned FRAME_LEN = TAG_BITS + SLOT_COUNT * SLOT_BITS;
    localparam int unsigned LEN_W     = $clog2(FRAME_LEN + 1);

    assign frame_last = (slot_idx == IDX_W'(SLOT_COUNT)) && (bit_pos == '0);

    // Step the bit position; at a slot's LSB move to the next slot or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_idx <= '0;
            bit_pos  <= POS_W'(TAG_BITS - 1);
        end else if (bit_pos == '0) begin
            if (slot_idx == IDX_W'(SLOT_COUNT)) begin
                slot_idx <= '0;
                bit_pos  <= POS_W'(TAG_BITS - 1);
            end else begin
                slot_idx <= slot_idx + 1'b1;
                bit_pos  <= POS_W'(SLOT_BITS - 1);
            end
        end else begin
            bit_pos <= bit_pos - 1'b1;
        end
    end

    // Checker-only frame length counter: clocks since the current frame began.
    logic [LEN_W-1:0] len_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || frame_last) len_cnt <= '0;
        else                      len_cnt <= len_cnt + 1'b1;
    end

    assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_idx <= IDX_W'(SLOT_COUNT));
    assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last |-> (len_cnt == LEN_W'(FRAME_LEN - 1)));
    assert_wrap_to_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last |=> (slot_idx == '0) && (bit_pos == POS_W'(TAG_BITS - 1)));
endmodule

// File: rtl/aclink_slot_buf.sv
// Module: one-word transmit buffer for a data slot, with its empty flag.
// It stores the low SLOT_BITS of a bus write. A consume pulse from the frame
// load sets the empty flag but keeps the word, so an underrun resends it.
// A write on the same edge as a consume wins the flag.
module aclink_slot_buf #(
    parameter int unsigned SLOT_BITS = 20,
    parameter int unsigned BUS_BITS  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [BUS_BITS-1:0]  wr_data,
    input  logic                 consume,
    output logic [SLOT_BITS-1:0] data_o,
    output logic                 empty_o
);
    // Hold the buffered word; only a write replaces it.
    always_ff @(posedge clk) begin
        if (!rst_n)     data_o <= '0;
        else if (wr_en) data_o <= wr_data[SLOT_BITS-1:0];
    end

    // Empty flag: cleared by a write, set when the frame takes the word.
    always_ff @(posedge clk) begin
        if (!rst_n)       empty_o <= 1'b1;
        else if (wr_en)   empty_o <= 1'b0;
        else if (consume) empty_o <= 1'b1;
    end

    assert_write_low_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (data_o == $past(wr_data[SLOT_BITS-1:0])) && !empty_o);
    assert_consume_sets_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !wr_en) |=> empty_o);
    assert_stale_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(data_o));
endmodule

// File: rtl/aclink_frame_shifter.sv
// Module: frame content and serial output. At the frame's last bit it takes
// the requested slots' valid bits and buffer words into shadow registers. The
// next frame is then driven from those, one registered bit per clock.
// Assumes slot_idx/bit_pos come from the frame timer (slot 0 = tag).
module aclink_frame_shifter #(
    parameter int unsigned TAG_BITS   = 16,
    parameter int unsigned SLOT_BITS  = 20,
    parameter int unsigned DATA_SLOTS = 4,
    parameter int unsigned IDX_W      = 4,
    parameter int unsigned POS_W      = 5
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [IDX_W-1:0]                     slot_idx,
    input  logic [POS_W-1:0]                     bit_pos,
    input  logic                                 frame_last,
    input  logic [DATA_SLOTS-1:0]                slot_req,
    input  logic [DATA_SLOTS-1:0][SLOT_BITS-1:0] buf_data,
    output logic                                 sdata_o,
    output logic                                 sync_o
);
    logic [DATA_SLOTS-1:0]                valid_q;
    logic [DATA_SLOTS-1:0][SLOT_BITS-1:0] shadow_q;
    logic                                 bit_nxt;

    // Latch which slots the coming frame carries.
    always_ff @(posedge clk) begin
        if (!rst_n)          valid_q <= '0;
        else if (frame_last) valid_q <= slot_req;
    end

    // One shadow word per data slot, loaded only when requested.
    for (genvar g = 0; g < DATA_SLOTS; g++) begin : g_shadow
        always_ff @(posedge clk) begin
            if (!rst_n)                        shadow_q[g] <= '0;
            else if (frame_last && slot_req[g]) shadow_q[g] <= buf_data[g];
        end
    end

    // Select the frame bit at the current slot and bit position.
    always_comb begin
        bit_nxt = 1'b0;
        if (slot_idx == '0) begin
            if (bit_pos == POS_W'(TAG_BITS - 1)) begin
                bit_nxt = |valid_q;
            end else begin
                for (int k = 0; k < DATA_SLOTS; k++) begin
                    if (bit_pos == POS_W'(TAG_BITS - 2 - k)) bit_nxt = valid_q[k];
                end
            end
        end else begin
            for (int k = 0; k < DATA_SLOTS; k++) begin
                if (slot_idx == IDX_W'(k + 1))
                    bit_nxt = valid_q[k] & shadow_q[k][bit_pos];
            end
        end
    end

    // Register the serial bit and the sync so both change on the clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdata_o <= 1'b0;
            sync_o  <= 1'b0;
        end else begin
            sdata_o <= bit_nxt;
            sync_o  <= (slot_idx == '0);
        end
    end

    assert_unused_slots_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx > IDX_W'(DATA_SLOTS)) |=> !sdata_o);
    assert_sync_in_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx == '0) |=> sync_o);
    assert_sync_off_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx != '0) |=> !sync_o);
    assert_frame_valid_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx == '0 && bit_pos == POS_W'(TAG_BITS - 1)) |=> (sdata_o == |valid_q));
endmodule

// File: rtl/aclink_tx_framer.sv
// Module: AC-link transmit frame serializer (top).
// It ties together the frame timer, one buffer per data slot, and the frame
// shifter. Everything runs on the codec bit clock; reset is synchronous and
// active low.
module aclink_tx_framer
    import aclink_tx_pkg::*;
#(
    parameter int unsigned TAG_BITS   = DEF_TAG_BITS,
    parameter int unsigned SLOT_BITS  = DEF_SLOT_BITS,
    parameter int unsigned SLOT_COUNT = DEF_SLOT_COUNT,
    parameter int unsigned DATA_SLOTS = DEF_DATA_SLOTS,
    parameter int unsigned BUS_BITS   = DEF_BUS_BITS
) (
    input  logic                  bit_clk,
    input  logic                  rst_n,
    input  logic [DATA_SLOTS-1:0] slot_req,
    input  logic [DATA_SLOTS-1:0] wr_en,
    input  logic [BUS_BITS-1:0]   wr_data,
    output logic                  sdata_out,
    output logic                  sync_out,
    output logic [DATA_SLOTS-1:0] buf_empty
);
    localparam int unsigned IDX_W = $clog2(SLOT_COUNT + 1);
    localparam int unsigned POS_W = $clog2(max_u(TAG_BITS, SLOT_BITS));

    logic [IDX_W-1:0]                     slot_idx;
    logic [POS_W-1:0]                     bit_pos;
    logic                                 frame_last;
    logic [DATA_SLOTS-1:0][SLOT_BITS-1:0] buf_data;

    aclink_frame_timer #(
        .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .SLOT_COUNT(SLOT_COUNT),
        .IDX_W(IDX_W), .POS_W(POS_W)
    ) timer_i (
        .clk(bit_clk), .rst_n(rst_n), .slot_idx(slot_idx),
        .bit_pos(bit_pos), .frame_last(frame_last)
    );

    for (genvar g = 0; g < DATA_SLOTS; g++) begin : g_buf
        aclink_slot_buf #(.SLOT_BITS(SLOT_BITS), .BUS_BITS(BUS_BITS)) buf_i (
            .clk(bit_clk), .rst_n(rst_n), .wr_en(wr_en[g]), .wr_data(wr_data),
            .consume(frame_last & slot_req[g]),
            .data_o(buf_data[g]), .empty_o(buf_empty[g])
        );
    end

    aclink_frame_shifter #(
        .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .DATA_SLOTS(DATA_SLOTS),
        .IDX_W(IDX_W), .POS_W(POS_W)
    ) shifter_i (
        .clk(bit_clk), .rst_n(rst_n), .slot_idx(slot_idx), .bit_pos(bit_pos),
        .frame_last(frame_last), .slot_req(slot_req), .buf_data(buf_data),
        .sdata_o(sdata_out), .sync_o(sync_out)
    );
endmodule

// File: tb/aclink_tx_framer_tb.sv
// Bench: directed and seeded-random frames against a bench-side model.
module aclink_tx_framer_tb_top;
    localparam int FLEN = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  slot_req = '0;
    logic [3:0]  wr_en = '0;
    logic [31:0] wr_data = '0;
    logic        sdata_out, sync_out;
    logic [3:0]  buf_empty;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench model state
    logic [3:0]       cur_valid = '0;
    logic [3:0][19:0] cur_shadow = '0;
    logic [3:0][19:0] mbuf = '0;
    logic [3:0]       mempty = 4'hF;

    always #2.5 clk = ~clk;

    aclink_tx_framer dut_i (
        .bit_clk(bit_clk_w), .rst_n(rst_n), .slot_req(slot_req), .wr_en(wr_en),
        .wr_data(wr_data), .sdata_out(sdata_out), .sync_out(sync_out),
        .buf_empty(buf_empty)
    );
    wire bit_clk_w = clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected frame: tag then twelve slots, MSB first, index 255 sent first.
    function automatic logic [FLEN-1:0] build_frame(input logic [3:0] v,
                                                    input logic [3:0][19:0] d);
        logic [FLEN-1:0] f = '0;
        f[255] = |v;
        for (int k = 0; k < 4; k++) begin
            f[254-k] = v[k];
            if (v[k]) f[239-20*k -: 20] = d[k];
        end
        return f;
    endfunction

    // Run one frame. Writes land mid-frame, or on the load edge if coincide.
    task automatic do_frame(input logic [3:0] req_next, input logic [3:0] wmask,
                            input logic [31:0] wdat, input bit coincide);
        logic [FLEN-1:0] got, exp;
        int sync_bad = 0;
        exp = build_frame(cur_valid, cur_shadow);
        for (int p = 0; p < FLEN; p++) begin
            @(posedge clk);
            @(negedge clk);
            got[FLEN-1-p] = sdata_out;
            if (sync_out != (p < 16)) sync_bad++;
            if (p == 0) chk(buf_empty == mempty, "R8 flags after load", buf_empty, mempty);
            if (p == 100 && !coincide && wmask != 0) begin
                wr_en = wmask; wr_data = wdat;
            end
            if (p == 101 && !coincide) begin
                wr_en = '0;
                for (int k = 0; k < 4; k++)
                    if (wmask[k]) begin mbuf[k] = wdat[19:0]; mempty[k] = 1'b0; end
            end
            if (p == 200) chk(buf_empty == mempty, "R8 flags after write", buf_empty, mempty);
            if (p == 254) begin
                slot_req = req_next;
                if (coincide) begin wr_en = wmask; wr_data = wdat; end
            end
            if (p == 255) wr_en = '0;
        end
        chk(sync_bad == 0, "R2 sync width", sync_bad, 0);
        chk(got[255:240] == exp[255:240], "R4 tag bits", got[255:240], exp[255:240]);
        for (int k = 0; k < 4; k++)
            chk(got[239-20*k -: 20] == exp[239-20*k -: 20], "R3/R5/R9 data slot",
                got[239-20*k -: 20], exp[239-20*k -: 20]);
        chk(got[159:0] == '0, "R6 slots 5-12 zero", got[31:0], 0);
        // Model the load edge: load first from old words, then coincident writes.
        cur_valid = req_next;
        for (int k = 0; k < 4; k++) begin
            if (req_next[k]) begin cur_shadow[k] = mbuf[k]; mempty[k] = 1'b1; end
            if (coincide && wmask[k]) begin mbuf[k] = wdat[19:0]; mempty[k] = 1'b0; end
        end
    endtask

    initial begin
        void'($urandom(32'h5A17));
        repeat (4) @(negedge clk);
        chk(sync_out == 1'b0 && sdata_out == 1'b0, "R1 reset outputs",
            {sync_out, sdata_out}, 0);
        chk(buf_empty == 4'hF, "R1 reset flags", buf_empty, 4'hF);
        rst_n = 1'b1;
        // R1: first frame empty; fill all four slots (R7 upper junk) and request all.
        do_frame(4'hF, 4'hF, 32'hFFF_A5C3E, 1'b0);
        // R5: all four slots carry data.
        do_frame(4'hF, 4'h0, '0, 1'b0);
        // R9: underrun resends the stale words; R10 coincident write to slot 2.
        do_frame(4'b0010, 4'b0010, 32'hABC1_2345, 1'b1);
        // R10: the old word goes out; the new word is requested next.
        do_frame(4'b0010, 4'h0, '0, 1'b0);
        // R4: no requests, so the tag is zero in the following frame.
        do_frame(4'h0, 4'b0101, 32'h0001_E00F, 1'b0);
        do_frame(4'b1001, 4'h0, '0, 1'b0);
        for (int i = 0; i < 24; i++)
            do_frame(4'($urandom), 4'($urandom), $urandom, ($urandom % 4) == 0);
        do_frame(4'h0, 4'h0, '0, 1'b0);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule